// File: doc/BRIEF.md
# Byte-Wide SPI Port with Sequenced Flag Clearing

This block is a single-byte synchronous serial port that sits on a small processor bus. It exposes three registers: control, status and data. As a master, it drives the serial clock and the outbound data line. Writing a byte to the data register starts an eight-bit exchange, MSB first. The byte the remote device had preloaded shifts in at the same time, so software can write a throwaway byte just to fetch remote data. As a slave, it follows an external serial clock while its select input is low, and returns the byte software preloaded.

Software sets the role, the bit rate, the clock idle level and the sampling edge. There are three sticky status flags: done, collision and fault. None of them clears on a single access. Each clears only after a status read that saw it set, followed by the matching register access: the data register for done and collision, and the control register for fault. A master whose select input is pulled low records a fault, gives up its role and enable, and releases its output drivers. `rdata` always shows the register picked by `addr`. Only accesses strobed with `rd_en`/`wr_en` count toward the clearing sequences.

Top module: `spi_port`

## Requirements
- R1: After reset, control, status and data read as 0x00, and `sck_oe`, `mosi_oe`, `miso_oe` and `irq` are 0.
- R2: With the port enabled as master, a write to the data register (address 2) sends that byte on `mosi_o` MSB first. The eight bits sampled from `miso_i` then read back from the data register.
- R3: Control bits [1:0] set the serial clock period to 2, 4, 16 or 32 system clocks for codes 0 to 3. The done flag rises 8 serial clock periods after the clock edge that accepted the data write.
- R4: Control bit 3 sets the serial clock idle level, and `sck_o` rests at that level between transfers. With control bit 2 clear, data is sampled on the leading edge and shifted on the trailing edge; with it set, the two edges swap roles. All four combinations exchange bytes correctly.
- R5: The done flag (status bit 7) clears only when a status read (address 1) that saw it set is followed by a data register read or write. A data register access with no such status read before it leaves the flag set.
- R6: A data register write during a transfer sets the collision flag (status bit 6) and is ignored, so the transfer finishes with the original byte. The collision flag clears by the same status-then-data sequence as the done flag.
- R7: If the port is an enabled master (control bits 6 and 4 set) and `ss_n_i` is low, the fault flag (status bit 4) sets, control bits 6 and 4 clear, and `sck_oe` and `mosi_oe` fall. The fault flag clears only when a status read that saw it set is followed by a control register write (address 0). A data register access does not clear it.
- R8: `irq` is high whenever control bit 7 is set and either the done flag or the fault flag is set.
- R9: As an enabled slave (bit 6 set, bit 4 clear) with `ss_n_i` low, the port drives `miso_oe`. It presents its preloaded byte on `miso_o` MSB first, following `sck_i` edges, and captures `mosi_i`. After eight clock cycles on `sck_i`, the received byte reads back and the done flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe, marks a read for flag sequencing |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Contents of the selected register |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock driver enable |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| mosi_oe | output | 1 | Serial data out driver enable |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Slave data driver enable |
| ss_n_i | input | 1 | Active-low select input |

## Verification
The bench goes after the flag sequencing corners. It does a data read without a prior status read, and it does a status read taken before the flag rose. A design that clears on any single access fails both, and so does one that latches a status read blindly. Collisions are forced in the middle of a slow transfer. A design that accepts the late write shifts out a corrupted byte and fails the MOSI comparison. A select-low fault is followed by a data access that must not clear it. A design that wires the fault clear to data accesses, or that leaves the master role set, shows up in the status register and the output enables. Randomized transfers across all rates and clock modes measure completion time and check both bytes. An off-by-one edge count or a swapped sampling edge corrupts the data or moves the done flag.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          mosi_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          miso_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          ss_n_i
);
  localparam int EW = $clog2(2*DW);
  localparam logic [EW-1:0] ELAST = EW'(2*DW-1);

  logic [7:0]    ctrl;
  logic          spif, wcol, modf, seen_spif, seen_wcol, seen_modf;
  logic [DW-1:0] sh, rbuf, nxt;
  logic          rxb, busy, sck_q, sck_d;
  logic [EW-1:0] ecnt;
  logic [3:0]    hcnt, half_m1;
  logic [1:0]    ss_s, sck_s, mosi_s;

  wire ie   = ctrl[7];
  wire en   = ctrl[6];
  wire mstr = ctrl[4];
  wire cpol = ctrl[3];
  wire cpha = ctrl[2];

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire rd_stat = rd_en && addr == 2'd1;
  wire wr_data = wr_en && addr == 2'd2;
  wire dacc    = (wr_en || rd_en) && addr == 2'd2;

  wire is_m      = en && mstr;
  wire slave_sel = en && !mstr && !ss_s[1];
  wire fault     = is_m && !ss_s[1];
  wire m_tick    = is_m && busy && hcnt == half_m1;
  wire tick      = m_tick || (slave_sel && (sck_s[1] ^ sck_d));
  wire last      = tick && ecnt == ELAST;
  wire samp      = ~ecnt[0] ^ cpha;
  wire miso_in   = is_m ? miso_i : mosi_s[1];
  wire active    = busy || (slave_sel && ecnt != '0);
  wire start     = wr_data && is_m && !busy && !fault;
  wire col       = wr_data && active;

  always_comb begin
    case (ctrl[1:0])
      2'd0:    half_m1 = 4'd0;
      2'd1:    half_m1 = 4'd1;
      2'd2:    half_m1 = 4'd7;
      default: half_m1 = 4'd15;
    endcase
  end

  assign nxt = {sh[DW-2:0], samp ? miso_in : rxb};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ss_s <= 2'b11; sck_s <= 2'b00; mosi_s <= 2'b00; sck_d <= 1'b0;
    end else begin
      ss_s   <= {ss_s[0], ss_n_i};
      sck_s  <= {sck_s[0], sck_i};
      mosi_s <= {mosi_s[0], mosi_i};
      sck_d  <= sck_s[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0; rbuf <= '0; rxb <= 1'b0; busy <= 1'b0;
      sck_q <= 1'b0; ecnt <= '0; hcnt <= '0;
    end else begin
      if (!busy && !slave_sel) begin
        ecnt  <= '0;
        sck_q <= 1'b0;
      end
      if (busy) hcnt <= m_tick ? 4'd0 : hcnt + 4'd1;
      if (tick) begin
        ecnt <= ecnt + 1'b1;
        if (is_m) sck_q <= ~sck_q;
        if (samp && !last) rxb <= miso_in;
        else if (samp || !(cpha && ecnt == '0)) sh <= nxt;
        if (last) begin
          rbuf <= nxt;
          busy <= 1'b0;
        end
      end
      if (start) begin
        sh <= wdata; busy <= 1'b1; hcnt <= '0; ecnt <= '0; sck_q <= 1'b0;
      end else if (wr_data && !active) begin
        sh <= wdata;
      end
      if (fault || !is_m) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; spif <= 1'b0; wcol <= 1'b0; modf <= 1'b0;
      seen_spif <= 1'b0; seen_wcol <= 1'b0; seen_modf <= 1'b0;
    end else begin
      if (rd_stat) begin
        seen_spif <= spif; seen_wcol <= wcol; seen_modf <= modf;
      end
      if (dacc && seen_spif) begin spif <= 1'b0; seen_spif <= 1'b0; end
      if (dacc && seen_wcol) begin wcol <= 1'b0; seen_wcol <= 1'b0; end
      if (wr_ctrl) begin
        ctrl <= wdata[7:0] & 8'hDF;
        if (seen_modf) begin modf <= 1'b0; seen_modf <= 1'b0; end
      end
      if (last) spif <= 1'b1;
      if (col)  wcol <= 1'b1;
      if (fault) begin
        modf <= 1'b1; ctrl[6] <= 1'b0; ctrl[4] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0:    rdata[7:0] = ctrl;
      2'd1:    rdata[7:4] = {spif, wcol, 1'b0, modf};
      2'd2:    rdata = rbuf;
      default: rdata = '0;
    endcase
  end

  assign sck_o   = cpol ^ sck_q;
  assign sck_oe  = is_m;
  assign mosi_o  = sh[DW-1];
  assign mosi_oe = is_m;
  assign miso_o  = sh[DW-1];
  assign miso_oe = slave_sel;
  assign irq     = ie && (spif || modf);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] ctrl,
  input logic       busy,
  input logic       tick,
  input logic       spif,
  input logic       wcol,
  input logic       modf,
  input logic       sck_o,
  input logic       sck_oe,
  input logic       mosi_o,
  input logic       irq
);
  p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && !busy) |-> sck_o == ctrl[3]);

  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && busy) |=> wcol);

  p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spif) |-> ($past(wr_en || rd_en) && $past(addr) == 2'd2));

  p_fault_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> (!ctrl[6] && !ctrl[4] && !sck_oe));

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(tick)) |-> $stable(mosi_o));

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && (spif || modf)) |-> irq);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .ctrl(ctrl), .busy(busy), .tick(tick), .spif(spif), .wcol(wcol),
  .modf(modf), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o), .irq(irq)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, sck_i = 1'b0, sck_o, sck_oe, mosi_i = 1'b0, mosi_o, mosi_oe;
  logic miso_i = 1'b0, miso_o, miso_oe, ss_n_i = 1'b1;

  int nchk = 0, nfail = 0;
  logic act = 1'b0, t_cpol = 1'b0, t_cpha = 1'b0, last_mosi = 1'b0;
  logic [7:0] slv_sh = '0, mrx = '0;

  always #(CLK_P/2) clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i)
  );

  always @(negedge clk) last_mosi <= mosi_o;

  always @(sck_o) begin
    if (act) begin
      if ((sck_o != t_cpol) == t_cpha) begin
        if (t_cpha) begin miso_i = slv_sh[7]; slv_sh = slv_sh << 1; end
        else begin slv_sh = slv_sh << 1; miso_i = slv_sh[7]; end
      end else begin
        mrx = {mrx[6:0], last_mosi};
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic int half_of(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_done(output int n);
    logic [7:0] s;
    n = 0; peek(2'd1, s);
    while (!s[7] && n < 1000) begin
      @(posedge clk); @(negedge clk); n++; peek(2'd1, s);
    end
  endtask

  task automatic arm(input logic ie, input logic [1:0] r, input logic cp, input logic ch,
                     input logic [7:0] sb);
    bus_wr(2'd0, {ie, 1'b1, 1'b0, 1'b1, cp, ch, r});
    t_cpol = cp; t_cpha = ch; slv_sh = sb; mrx = '0;
    miso_i = ch ? 1'b0 : sb[7];
    act = 1'b1;
  endtask

  task automatic xfer(input logic [1:0] r, input logic cp, input logic ch,
                      input logic [7:0] mb, input logic [7:0] sb);
    logic [7:0] d;
    int n;
    arm(1'b0, r, cp, ch, sb);
    @(negedge clk);
    chk("R4 idle level before", sck_o, cp);
    bus_wr(2'd2, mb);
    wait_done(n);
    chk("R3 cycles to done", n, 16 * half_of(r));
    act = 1'b0;
    chk("R2 mosi byte", mrx, mb);
    peek(2'd2, d);
    chk("R2 R4 received byte", d, sb);
    chk("R4 idle level after", sck_o, cp);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
    peek(2'd1, d);
    chk("R5 done cleared", d[7], 1'b0);
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d, mb, sb;
    int n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(2'd0, d); chk("R1 control reset", d, 8'h00);
    peek(2'd1, d); chk("R1 status reset", d, 8'h00);
    peek(2'd2, d); chk("R1 data reset", d, 8'h00);
    chk("R1 enables reset", {sck_oe, mosi_oe, miso_oe, irq}, 4'b0000);

    xfer(2'd0, 1'b0, 1'b0, 8'hA5, 8'h3C);
    xfer(2'd3, 1'b1, 1'b1, 8'h00, 8'hFF);
    xfer(2'd1, 1'b1, 1'b0, 8'hFF, 8'h01);
    xfer(2'd2, 1'b0, 1'b1, 8'h80, 8'h7E);
    for (int i = 0; i < 20; i++) begin
      mb = 8'($urandom); sb = 8'($urandom);
      xfer(2'($urandom), 1'($urandom), 1'($urandom), mb, sb);
    end

    // R5: data access alone does not clear, stale status read does not count
    arm(1'b1, 2'd0, 1'b0, 1'b0, 8'h5A);
    bus_rd(2'd1, d);
    bus_wr(2'd2, 8'hC3);
    wait_done(n);
    act = 1'b0;
    chk("R8 irq with done", irq, 1'b1);
    bus_rd(2'd2, d);
    peek(2'd1, d); chk("R5 stale status read keeps done", d[7], 1'b1);
    bus_rd(2'd2, d);
    peek(2'd1, d); chk("R5 data read alone keeps done", d[7], 1'b1);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
    peek(2'd1, d); chk("R5 status then data clears", d[7], 1'b0);
    chk("R8 irq drops", irq, 1'b0);

    // R6: collision during slow transfer
    arm(1'b0, 2'd3, 1'b0, 1'b0, 8'h96);
    bus_wr(2'd2, 8'h4B);
    repeat (40) @(negedge clk);
    bus_wr(2'd2, 8'hFF);
    peek(2'd1, d); chk("R6 collision flag set", d[6], 1'b1);
    wait_done(n);
    act = 1'b0;
    chk("R6 ignored write leaves mosi", mrx, 8'h4B);
    peek(2'd2, d); chk("R6 received intact", d, 8'h96);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
    peek(2'd1, d); chk("R6 collision cleared", d[7:6], 2'b00);

    // R7 and R8: mode fault
    bus_wr(2'd0, 8'hD0);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    ss_n_i = 1'b1;
    peek(2'd1, d); chk("R7 fault flag set", d[4], 1'b1);
    peek(2'd0, d); chk("R7 role and enable cleared", {d[6], d[4]}, 2'b00);
    chk("R7 drivers released", {sck_oe, mosi_oe}, 2'b00);
    chk("R8 irq with fault", irq, 1'b1);
    bus_rd(2'd1, d);
    bus_rd(2'd2, d);
    peek(2'd1, d); chk("R7 data access keeps fault", d[4], 1'b1);
    bus_rd(2'd1, d);
    bus_wr(2'd0, 8'h80);
    peek(2'd1, d); chk("R7 status then control clears", d[4], 1'b0);
    chk("R8 irq after fault clear", irq, 1'b0);

    // R9: slave exchange
    mb = 8'hB2; sb = 8'h6D;
    bus_wr(2'd0, 8'h40);
    bus_wr(2'd2, sb);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 miso driven", {miso_oe, sck_oe}, 2'b10);
    for (int i = 7; i >= 0; i--) begin
      mosi_i = mb[i];
      repeat (4) @(negedge clk);
      chk("R9 miso bit", miso_o, sb[i]);
      sck_i = 1'b1;
      repeat (6) @(negedge clk);
      sck_i = 1'b0;
      repeat (6) @(negedge clk);
    end
    peek(2'd1, d); chk("R9 slave done", d[7], 1'b1);
    peek(2'd2, d); chk("R9 slave received", d, mb);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 miso released", miso_oe, 1'b0);

    summary();
  end
endmodule